// File: doc/BRIEF.md
# Set-Associative Tag Controller with Shared Victim Pool

This block keeps the tags and valid bits of a set-associative cache and decides which lines stay in it. Each set owns a few private ways. The sets also share one pool of spare entries. A lookup searches the private ways of the addressed set and the entire shared pool in the same cycle. It reports a hit or a miss, and for a hit it reports which of the two storages holds the line.

On a miss the line is written into a private way. The private way is chosen cheaply: the lowest-numbered empty way if one exists, otherwise the way under a per-set rotating pointer. No recency is tracked for private ways. A valid line pushed out of its private way is not dropped. It moves into the shared pool, which tracks recency across all of its entries with an age matrix. When the pool has no free entry, its least recently used entry leaves on the eviction port in the same cycle, so a busy set can hold more lines than its own private ways.

A hit in the pool moves the line back into the private ways of its set. The private line it displaces takes over the freed pool entry as the most recently used one. Only tags and valid bits are kept. Data arrays, coherence and writeback are outside the block.

Top module: `vr_cache_ctrl`

## Requirements
- R1: After reset every private way and every pool entry is empty, so the first request to any address misses and produces no eviction.
- R2: A request whose tag is valid in a private way of its set reports rsp_hit=1, rsp_rsv=0 and changes no state. The address layout is {tag, set}, with the set index in the low SET_BITS bits.
- R3: A miss writes the tag into the lowest-numbered empty private way of the set when one exists, and reports rsp_hit=0.
- R4: When all private ways of the set are full, a fill (a miss or a pool swap) uses the way under the set's rotating pointer. After every fill into way w, the pointer moves to w+1 modulo the number of private ways. The pointer of every set starts at way 0.
- R5: A valid line displaced from a private way enters the pool. A later request for it reports rsp_hit=1, rsp_rsv=1. A tag and set pair is held in at most one pool entry.
- R6: A pool hit moves the line into its set's private storage and puts the displaced private line into the freed pool entry. A repeat of the request then hits private storage.
- R7: The pool is shared: lines displaced from different sets coexist in it, and each is matched only by requests to its own set.
- R8: When a displaced line must enter a full pool, the least recently used pool entry is reported on evict_valid, evict_tag and evict_set in the same cycle as the miss.
- R9: A pool entry becomes most recently used when it is written by an insert and when a pool hit refills it with the displaced line.
- R10: With req_valid low, rsp_hit, rsp_rsv and evict_valid are 0 and no state changes.
- R11: While a pool entry is free, a displaced line takes the free entry and nothing is evicted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | TAG_W+SET_BITS | Request address {tag, set} |
| rsp_hit | output | 1 | The request hit (combinational, same cycle) |
| rsp_rsv | output | 1 | The hit came from the shared pool |
| evict_valid | output | 1 | A pool entry leaves the cache this cycle |
| evict_tag | output | TAG_W | Tag of the evicted line |
| evict_set | output | SET_BITS | Owner set of the evicted line |

## Verification
Two events can occur in one cycle: a miss that places a line into a private way, and the pool eviction forced by that same fill. The bench provokes this by overfilling several sets until the pool is full. It then keeps sending misses to sets whose private ways are occupied, mixed with pool hits that reorder recency. In each such cycle a behavioural model, built from queues, predicts the response flags and the identity of the least recently used entry. Every cycle, the evicted tag and set on the port must match that prediction.

// File: rtl/vr_pkg.sv
package vr_pkg;
    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_PHIT = 2'd1,
        ACT_RHIT = 2'd2,
        ACT_MISS = 2'd3
    } vr_act_e;
endpackage

// File: rtl/vr_pick_low.sv
module vr_pick_low #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/vr_age_lru.sv
module vr_age_lru #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] lru_idx
);
    // older_q[i][j] = 1 : entry i was used before entry j
    logic [N-1:0][N-1:0] older_d, older_q;
    logic [N-1:0]        is_lru;

    always_comb begin
        older_d = older_q;
        if (touch_en) begin
            for (int j = 0; j < N; j++) begin
                older_d[touch_idx][j] = 1'b0;
                if (IW'(j) != touch_idx) older_d[j][touch_idx] = 1'b1;
            end
        end
        for (int i = 0; i < N; i++) begin
            is_lru[i] = 1'b1;
            for (int j = 0; j < N; j++) begin
                if (i != j && !older_q[i][j]) is_lru[i] = 1'b0;
            end
        end
        lru_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (is_lru[i]) lru_idx = IW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    older_q[i][j] <= (i < j);
        end else begin
            older_q <= older_d;
        end
    end
endmodule

// File: rtl/vr_cache_ctrl.sv
module vr_cache_ctrl #(
    parameter int TAG_W    = 8,
    parameter int SET_BITS = 2,
    parameter int PWAYS    = 2,
    parameter int RSV      = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [TAG_W+SET_BITS-1:0] req_addr,
    output logic                      rsp_hit,
    output logic                      rsp_rsv,
    output logic                      evict_valid,
    output logic [TAG_W-1:0]          evict_tag,
    output logic [SET_BITS-1:0]       evict_set
);
    import vr_pkg::*;

    localparam int SETS = 1 << SET_BITS;
    localparam int PW_W = (PWAYS > 1) ? $clog2(PWAYS) : 1;
    localparam int RW   = (RSV > 1) ? $clog2(RSV) : 1;

    typedef struct packed {
        logic [SETS-1:0][PWAYS-1:0][TAG_W-1:0] ptag;
        logic [SETS-1:0][PWAYS-1:0]            pval;
        logic [SETS-1:0][PW_W-1:0]             rr;
        logic [RSV-1:0][TAG_W-1:0]             rtag;
        logic [RSV-1:0][SET_BITS-1:0]          rset;
        logic [RSV-1:0]                        rval;
    } st_t;

    st_t st_d, st_q;

    logic [SET_BITS-1:0] req_set;
    logic [TAG_W-1:0]    req_tag;
    logic [PWAYS-1:0]    priv_match;
    logic [RSV-1:0]      rsv_match;
    logic                rsv_full;
    logic                inv_found, rhit_found, rfree_found;
    logic [PW_W-1:0]     inv_way, vic_way, next_ptr;
    logic [RW-1:0]       rhit_idx, rfree_idx, lru_idx, rsv_tgt;
    logic                disp_valid;
    logic [TAG_W-1:0]    disp_tag;
    logic                touch_en;
    vr_act_e             act;

    assign req_set  = req_addr[SET_BITS-1:0];
    assign req_tag  = req_addr[TAG_W+SET_BITS-1:SET_BITS];
    assign rsv_full = &st_q.rval;

    for (genvar w = 0; w < PWAYS; w++) begin : g_pm
        assign priv_match[w] = st_q.pval[req_set][w] && (st_q.ptag[req_set][w] == req_tag);
    end
    for (genvar e = 0; e < RSV; e++) begin : g_rm
        assign rsv_match[e] = st_q.rval[e] && (st_q.rset[e] == req_set) && (st_q.rtag[e] == req_tag);
    end

    vr_pick_low #(.N(PWAYS), .IW(PW_W)) u_inv_pick (
        .vec(~st_q.pval[req_set]), .found(inv_found), .idx(inv_way));
    vr_pick_low #(.N(RSV), .IW(RW)) u_rhit_pick (
        .vec(rsv_match), .found(rhit_found), .idx(rhit_idx));
    vr_pick_low #(.N(RSV), .IW(RW)) u_free_pick (
        .vec(~st_q.rval), .found(rfree_found), .idx(rfree_idx));
    vr_age_lru #(.N(RSV), .IW(RW)) u_lru (
        .clk(clk), .rst_n(rst_n), .touch_en(touch_en),
        .touch_idx(rsv_tgt), .lru_idx(lru_idx));

    assign vic_way    = inv_found ? inv_way : st_q.rr[req_set];
    assign next_ptr   = (32'(vic_way) == PWAYS - 1) ? '0 : vic_way + 1'b1;
    assign disp_valid = st_q.pval[req_set][vic_way];
    assign disp_tag   = st_q.ptag[req_set][vic_way];
    assign rsv_tgt    = (act == ACT_RHIT) ? rhit_idx : (rfree_found ? rfree_idx : lru_idx);

    always_comb begin
        st_d        = st_q;
        act         = ACT_IDLE;
        touch_en    = 1'b0;
        evict_valid = 1'b0;
        evict_tag   = '0;
        evict_set   = '0;
        if (req_valid) begin
            if (|priv_match)     act = ACT_PHIT;
            else if (rhit_found) act = ACT_RHIT;
            else                 act = ACT_MISS;
        end
        if (act == ACT_RHIT || act == ACT_MISS) begin
            st_d.ptag[req_set][vic_way] = req_tag;
            st_d.pval[req_set][vic_way] = 1'b1;
            st_d.rr[req_set]            = next_ptr;
        end
        if (act == ACT_RHIT) begin
            if (disp_valid) begin
                st_d.rtag[rhit_idx] = disp_tag;
                st_d.rset[rhit_idx] = req_set;
                touch_en            = 1'b1;
            end else begin
                st_d.rval[rhit_idx] = 1'b0;
            end
        end
        if (act == ACT_MISS && disp_valid) begin
            if (!rfree_found) begin
                evict_valid = 1'b1;
                evict_tag   = st_q.rtag[lru_idx];
                evict_set   = st_q.rset[lru_idx];
            end
            st_d.rtag[rsv_tgt] = disp_tag;
            st_d.rset[rsv_tgt] = req_set;
            st_d.rval[rsv_tgt] = 1'b1;
            touch_en           = 1'b1;
        end
        rsp_hit = (act == ACT_PHIT) || (act == ACT_RHIT);
        rsp_rsv = (act == ACT_RHIT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/vr_cache_ctrl_chk.sv
module vr_cache_ctrl_chk #(
    parameter int TAG_W    = 8,
    parameter int SET_BITS = 2,
    parameter int RSV      = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic [TAG_W+SET_BITS-1:0] req_addr,
    input logic                      rsp_hit,
    input logic                      rsp_rsv,
    input logic                      evict_valid,
    input logic                      rsv_full,
    input logic [RSV-1:0]            rsv_match
);
    p_rsv_implies_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rsv |-> rsp_hit);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!rsp_hit && !rsp_rsv && !evict_valid));

    p_evict_on_full_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> (!rsp_hit && rsv_full));

    p_repeat_hits_private_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(req_valid) && req_addr == $past(req_addr)) |-> (rsp_hit && !rsp_rsv));

    p_unique_pool_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsv_match));
endmodule

bind vr_cache_ctrl vr_cache_ctrl_chk #(
    .TAG_W(TAG_W), .SET_BITS(SET_BITS), .RSV(RSV)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_hit(rsp_hit), .rsp_rsv(rsp_rsv), .evict_valid(evict_valid),
    .rsv_full(rsv_full), .rsv_match(rsv_match)
);

// File: tb/vr_cache_ctrl_tb.sv
module vr_cache_ctrl_tb_top;
    localparam int TAG_W = 8, SET_BITS = 2, PWAYS = 2, RSV = 4;
    localparam int SETS = 1 << SET_BITS;
    localparam int AW = TAG_W + SET_BITS;

    logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic rsp_hit, rsp_rsv, evict_valid;
    logic [TAG_W-1:0] evict_tag;
    logic [SET_BITS-1:0] evict_set;

    always #4 clk = ~clk;

    vr_cache_ctrl #(.TAG_W(TAG_W), .SET_BITS(SET_BITS), .PWAYS(PWAYS), .RSV(RSV)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_hit(rsp_hit), .rsp_rsv(rsp_rsv), .evict_valid(evict_valid),
        .evict_tag(evict_tag), .evict_set(evict_set));

    int checks = 0, errors = 0;
    bit done = 0;

    // behavioural model
    int m_tag [SETS][PWAYS];
    bit m_val [SETS][PWAYS];
    int m_ptr [SETS];
    int q_tag [$];
    int q_set [$];

    task automatic model_reset();
        for (int s = 0; s < SETS; s++) begin
            m_ptr[s] = 0;
            for (int w = 0; w < PWAYS; w++) begin m_val[s][w] = 0; m_tag[s][w] = 0; end
        end
        q_tag.delete(); q_set.delete();
    endtask

    task automatic step(input bit v, input int tag, input int set, input string rq);
        bit eh, er, ev;
        int et, es, vw, k;
        bit ph;
        @(negedge clk);
        req_valid = v;
        req_addr  = AW'(tag * SETS + set);
        #2;
        eh = 0; er = 0; ev = 0; et = 0; es = 0;
        if (v) begin
            ph = 0;
            for (int w = 0; w < PWAYS; w++) if (m_val[set][w] && m_tag[set][w] == tag) ph = 1;
            k = -1;
            for (int i = 0; i < q_tag.size(); i++) if (q_tag[i] == tag && q_set[i] == set) k = i;
            vw = m_ptr[set];
            for (int w = PWAYS - 1; w >= 0; w--) if (!m_val[set][w]) vw = w;
            if (ph) begin
                eh = 1;
            end else begin
                eh = (k >= 0); er = (k >= 0);
                if (k >= 0) begin q_tag.delete(k); q_set.delete(k); end
                if (m_val[set][vw]) begin
                    if (k < 0 && q_tag.size() == RSV) begin
                        ev = 1; et = q_tag.pop_front(); es = q_set.pop_front();
                    end
                    q_tag.push_back(m_tag[set][vw]); q_set.push_back(set);
                end
                m_tag[set][vw] = tag; m_val[set][vw] = 1;
                m_ptr[set] = (vw + 1) % PWAYS;
            end
        end
        checks++;
        if (rsp_hit !== eh || rsp_rsv !== er || evict_valid !== ev ||
            (ev && (evict_tag !== TAG_W'(et) || evict_set !== SET_BITS'(es)))) begin
            errors++;
            $display("FAIL %s addr t%0d/s%0d: actual hit=%b rsv=%b ev=%b tag=%0d set=%0d expected hit=%b rsv=%b ev=%b tag=%0d set=%0d",
                     rq, tag, set, rsp_hit, rsp_rsv, evict_valid, evict_tag, evict_set,
                     eh, er, ev, et, es);
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, "R10");          // idle after reset
        step(1, 1, 0, "R1");           // empty cache misses
        step(1, 2, 0, "R3");           // second empty way
        step(1, 1, 0, "R2");
        step(1, 2, 0, "R2");
        step(1, 3, 0, "R4");           // pointer at way 0, tag 1 displaced
        step(1, 4, 0, "R4");           // pointer at way 1, tag 2 displaced
        step(1, 1, 0, "R5");           // pool hit
        step(1, 1, 0, "R6");           // now private
        step(0, 1, 0, "R10");
        step(1, 1, 1, "R7");           // same tag, other set: miss
        step(1, 2, 1, "R7");
        step(1, 3, 1, "R11");          // pool fills without eviction
        step(1, 4, 1, "R11");
        step(1, 1, 1, "R7");           // pool hit for set 1 line
        step(1, 2, 0, "R9");           // touch entry -> most recent
        step(1, 5, 2, "R3");
        step(1, 6, 2, "R3");
        step(1, 7, 2, "R8");           // full pool: LRU leaves
        step(1, 8, 2, "R8");
        step(1, 9, 2, "R8");
        step(1, 5, 2, "R9");
        for (int n = 0; n < 1500; n++)
            step(($urandom_range(0, 9) < 8), $urandom_range(0, 6), $urandom_range(0, SETS - 1), "R8/R9 mix");
        // reset again: everything empty (R1)
        @(negedge clk); rst_n = 1'b0; req_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1; model_reset();
        step(1, 5, 2, "R1");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all requirements: actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule